// File: doc/BRIEF.md
# Front-Porch Command Window Scheduler

This block decides when queued command packets may be slipped into the vertical front porch of a video stream. The video timing sequencer gives it a strobe when the active picture region ends and a strobe at every line boundary. From those, the block counts front-porch lines. It keeps commands out for a protected number of lines, then opens a command window that lasts a set number of lines, and then closes it again.

While the window is open, the block issues a one-cycle grant per packet to the command encoder. It does so only when the command queue holds something, the encoder is idle and the link runs in high-speed mode. Transmission starts a programmable number of cycles into the window. The number of packets per window is either one or a programmed count. A one-shot mode limits command traffic to the single front porch that software arms with a ready bit. The ready bit clears itself once that window has been used. If a transfer is still running when the window closes, the block pulses a sync-override flag so that the timing logic knows a command has spilled into sync timing.

Top module: `vfp_cmd_sched`

## Requirements
- R1: After reset, `cmd_grant`, `win_open`, `ready_armed` and `sync_override` are all 0.
- R2: Let S be `cfg_stable_lines`. `win_open` rises in the cycle after the S-th `line_strobe` that follows `active_end`. When S is 0, it rises in the cycle after `active_end` itself.
- R3: Let A be `cfg_allow_lines`. The window stays open for exactly A lines, which is A line periods of cycles, and falls in the cycle after the A-th line strobe counted from its opening. When A is 0, no window opens.
- R4: Let P be `cfg_send_point`, and call the first cycle with `win_open` high cycle 0. No grant occurs before cycle P. With the queue pending and the encoder idle, the first grant comes in cycle P.
- R5: When `cfg_multi_en` is 0, at most one grant is issued per window. When it is 1, at most `cfg_pkt_count` grants are issued, and a count of 0 allows none. Grants are issued on consecutive eligible cycles until that limit is reached or the window closes.
- R6: The packet count and the cycle offset start again at zero in every window, so each new window can again issue its full limit.
- R7: When `cfg_frame_once` is 0, every window grants. When it is 1, a window grants only if `ready_armed` was 1 when the window opened.
- R8: A pulse on `arm_ready` sets `ready_armed`. In one-shot mode, `ready_armed` clears in the cycle after an armed window closes. A set in the same cycle takes priority over the clear.
- R9: While `lp_mode` is 1, no grant is issued. The window itself still opens and closes.
- R10: A grant is issued only in cycles where `cmd_pending` is 1 and `xfer_busy` is 0.
- R11: `sync_override` pulses for one cycle, in the cycle after the window closes, if `xfer_busy` was 1 at the closing edge. Otherwise it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| active_end | input | 1 | One-cycle strobe at the end of the active picture region |
| line_strobe | input | 1 | One-cycle strobe at each line boundary |
| cmd_pending | input | 1 | Command queue holds at least one packet |
| xfer_busy | input | 1 | Command encoder is transmitting a packet |
| lp_mode | input | 1 | Link is in low-power mode (1) rather than high-speed mode (0) |
| cfg_stable_lines | input | 11 | Protected front-porch lines before the window opens |
| cfg_allow_lines | input | 4 | Length of the command window in lines |
| cfg_send_point | input | 12 | Cycle offset in the window of the first grant |
| cfg_pkt_count | input | 16 | Packet limit per window in multi-packet mode |
| cfg_multi_en | input | 1 | 1: multi-packet limit, 0: one packet per window |
| cfg_frame_once | input | 1 | 1: grant only in armed windows |
| arm_ready | input | 1 | Pulse that arms the ready bit |
| cmd_grant | output | 1 | One-cycle grant for one packet |
| win_open | output | 1 | Command window is open |
| ready_armed | output | 1 | One-shot ready bit |
| sync_override | output | 1 | A transfer ran past the window close |

## Verification
The bench sweeps the stable count, the window length, the send point and the packet limit. One send point is placed so late that the window closes before the limit is reached. A scheduler that counted the window from the wrong strobe, or that registered one cycle too many or too few, would show a different number of open cycles or a shifted first grant. A packet counter that did not clear between windows would starve every window after the first. A limit of zero that was treated as one would leak a packet. The one-shot tests check that an unarmed window stays silent, that an armed window grants exactly once and that the ready bit drops afterwards. Separate frames hold the link in low-power mode, leave the queue empty, and keep the encoder busy across the close. A design that ignored mode, queue state or encoder state would grant in those frames, and one that missed the spill-over would give no override pulse.

// File: rtl/vfp_sched_pkg.sv
// Shared types for the front-porch command scheduler.
package vfp_sched_pkg;
    // Position of the scheduler within the front porch
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HOLD = 2'd1,
        PH_OPEN = 2'd2
    } phase_t;
endpackage

// File: rtl/vfp_phase.sv
// Line-phase tracker. It counts line strobes after the active region ends,
// holds for cfg_stable lines, then keeps the window open for cfg_allow lines.
// Assumes that active_end and line_strobe are one-cycle pulses. An
// active_end pulse restarts the sequence from any phase.
module vfp_phase
    import vfp_sched_pkg::*;
#(
    parameter int STABLE_W = 11,
    parameter int ALLOW_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                active_end,
    input  logic                line_strobe,
    input  logic [STABLE_W-1:0] cfg_stable,
    input  logic [ALLOW_W-1:0]  cfg_allow,
    output logic                win_open,
    output logic                close_now
);
    localparam int CNT_W = (STABLE_W > ALLOW_W) ? STABLE_W : ALLOW_W;

    phase_t             phase_q, phase_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [CNT_W-1:0]   cnt_inc;
    logic [CNT_W-1:0]   stable_x, allow_x;
    logic               allow_nz;

    assign stable_x = CNT_W'(cfg_stable);
    assign allow_x  = CNT_W'(cfg_allow);
    assign allow_nz = (cfg_allow != '0);
    assign cnt_inc  = cnt_q + 1'b1;

    // Next phase and line count from strobes and configuration
    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        if (active_end) begin
            cnt_d = '0;
            if (cfg_stable == '0) begin
                phase_d = allow_nz ? PH_OPEN : PH_IDLE;
            end else begin
                phase_d = PH_HOLD;
            end
        end else if (line_strobe) begin
            case (phase_q)
                PH_HOLD: begin
                    if (cnt_inc == stable_x) begin
                        cnt_d   = '0;
                        phase_d = allow_nz ? PH_OPEN : PH_IDLE;
                    end else begin
                        cnt_d = cnt_inc;
                    end
                end
                PH_OPEN: begin
                    if (cnt_inc == allow_x) begin
                        cnt_d   = '0;
                        phase_d = PH_IDLE;
                    end else begin
                        cnt_d = cnt_inc;
                    end
                end
                default: begin
                    cnt_d = '0;
                end
            endcase
        end
    end

    // Phase and count registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    assign win_open  = (phase_q == PH_OPEN);
    assign close_now = win_open && (phase_d != PH_OPEN);
endmodule

// File: rtl/vfp_arm.sv
// One-shot ready bit. An arm pulse sets it. In one-shot mode it clears when
// a window that was armed at its opening closes. Eligibility is sampled at
// the opening edge and held for the rest of the window.
module vfp_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic cfg_once,
    input  logic win_open,
    input  logic close_now,
    output logic ready,
    output logic eligible
);
    logic elig_q;

    // Ready bit: set has priority over the self-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready <= 1'b0;
        end else if (arm) begin
            ready <= 1'b1;
        end else if (close_now && cfg_once && elig_q) begin
            ready <= 1'b0;
        end
    end

    // Track ready while closed so the value at the opening edge is kept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elig_q <= 1'b0;
        end else if (!win_open) begin
            elig_q <= ready;
        end
    end

    assign eligible = !cfg_once || elig_q;
endmodule

// File: rtl/vfp_grant.sv
// Grant generator. While the window is open it counts cycles from the
// opening and packets granted. It issues one-cycle grants from the send
// point on, up to the packet limit. Both counters clear while the window is
// closed, so every window starts fresh.
module vfp_grant #(
    parameter int SP_W  = 12,
    parameter int PKT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_open,
    input  logic             eligible,
    input  logic             lp_mode,
    input  logic             cmd_pending,
    input  logic             xfer_busy,
    input  logic [SP_W-1:0]  cfg_send_point,
    input  logic             cfg_multi,
    input  logic [PKT_W-1:0] cfg_pkt_count,
    output logic             grant
);
    localparam logic [SP_W-1:0]  CYC_MAX = '1;
    localparam logic [PKT_W-1:0] ONE_PKT = PKT_W'(1);

    logic [SP_W-1:0]  cyc_q;
    logic [PKT_W:0]   sent_q;
    logic [PKT_W-1:0] limit;

    assign limit = cfg_multi ? cfg_pkt_count : ONE_PKT;

    // Saturating cycle offset inside the window
    always_ff @(posedge clk) begin
        if (!rst_n || !win_open) begin
            cyc_q <= '0;
        end else if (cyc_q != CYC_MAX) begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    // Packets granted in the current window
    always_ff @(posedge clk) begin
        if (!rst_n || !win_open) begin
            sent_q <= '0;
        end else if (grant) begin
            sent_q <= sent_q + 1'b1;
        end
    end

    // Grant qualification
    always_comb begin
        grant = win_open && eligible && !lp_mode && cmd_pending && !xfer_busy
                && (cyc_q >= cfg_send_point)
                && (sent_q < {1'b0, limit});
    end
endmodule

// File: rtl/vfp_cmd_sched.sv
// Front-porch command window scheduler, top level. It ties together the
// line-phase tracker, the one-shot ready bit and the grant generator, and
// it flags transfers that are still running when the window closes.
// Assumes that the strobes come from the video timing sequencer in this
// clock domain.
module vfp_cmd_sched #(
    parameter int STABLE_W = 11,
    parameter int ALLOW_W  = 4,
    parameter int SP_W     = 12,
    parameter int PKT_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                active_end,
    input  logic                line_strobe,
    input  logic                cmd_pending,
    input  logic                xfer_busy,
    input  logic                lp_mode,
    input  logic [STABLE_W-1:0] cfg_stable_lines,
    input  logic [ALLOW_W-1:0]  cfg_allow_lines,
    input  logic [SP_W-1:0]     cfg_send_point,
    input  logic [PKT_W-1:0]    cfg_pkt_count,
    input  logic                cfg_multi_en,
    input  logic                cfg_frame_once,
    input  logic                arm_ready,
    output logic                cmd_grant,
    output logic                win_open,
    output logic                ready_armed,
    output logic                sync_override
);
    logic close_now;
    logic eligible;

    vfp_phase #(.STABLE_W(STABLE_W), .ALLOW_W(ALLOW_W)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_end (active_end),
        .line_strobe(line_strobe),
        .cfg_stable (cfg_stable_lines),
        .cfg_allow  (cfg_allow_lines),
        .win_open   (win_open),
        .close_now  (close_now)
    );

    vfp_arm u_arm (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm_ready),
        .cfg_once (cfg_frame_once),
        .win_open (win_open),
        .close_now(close_now),
        .ready    (ready_armed),
        .eligible (eligible)
    );

    vfp_grant #(.SP_W(SP_W), .PKT_W(PKT_W)) u_grant (
        .clk           (clk),
        .rst_n         (rst_n),
        .win_open      (win_open),
        .eligible      (eligible),
        .lp_mode       (lp_mode),
        .cmd_pending   (cmd_pending),
        .xfer_busy     (xfer_busy),
        .cfg_send_point(cfg_send_point),
        .cfg_multi     (cfg_multi_en),
        .cfg_pkt_count (cfg_pkt_count),
        .grant         (cmd_grant)
    );

    // Register a pulse when a transfer is still running at the window close
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_override <= 1'b0;
        end else begin
            sync_override <= close_now && xfer_busy;
        end
    end
endmodule

// File: rtl/vfp_sched_chk.sv
// Property checker for vfp_cmd_sched, attached with bind. It keeps its own
// count of grants per window to check the packet limit.
module vfp_sched_chk #(
    parameter int PKT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             active_end,
    input logic             line_strobe,
    input logic             cmd_pending,
    input logic             xfer_busy,
    input logic             lp_mode,
    input logic [PKT_W-1:0] cfg_pkt_count,
    input logic             cfg_multi_en,
    input logic             cfg_frame_once,
    input logic             arm_ready,
    input logic             cmd_grant,
    input logic             win_open,
    input logic             ready_armed,
    input logic             sync_override
);
    logic [PKT_W:0] gcnt;

    // Independent grant count for the current window
    always_ff @(posedge clk) begin
        if (!rst_n || !win_open) begin
            gcnt <= '0;
        end else if (cmd_grant) begin
            gcnt <= gcnt + 1'b1;
        end
    end

    assert_grant_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_grant |-> win_open);

    assert_open_after_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_open) |-> $past(line_strobe || active_end));

    assert_pkt_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_grant |-> (gcnt < (cfg_multi_en ? {1'b0, cfg_pkt_count} : (PKT_W+1)'(1))));

    assert_no_lp_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_grant |-> !lp_mode);

    assert_grant_qualified_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_grant |-> (cmd_pending && !xfer_busy));

    assert_override_at_close_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sync_override |-> ($past(win_open) && $past(xfer_busy)));

    assert_ready_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_armed) |-> ($past(win_open) && $past(cfg_frame_once)));

    assert_ready_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        arm_ready |=> ready_armed);
endmodule

bind vfp_cmd_sched vfp_sched_chk #(.PKT_W(PKT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .active_end    (active_end),
    .line_strobe   (line_strobe),
    .cmd_pending   (cmd_pending),
    .xfer_busy     (xfer_busy),
    .lp_mode       (lp_mode),
    .cfg_pkt_count (cfg_pkt_count),
    .cfg_multi_en  (cfg_multi_en),
    .cfg_frame_once(cfg_frame_once),
    .arm_ready     (arm_ready),
    .cmd_grant     (cmd_grant),
    .win_open      (win_open),
    .ready_armed   (ready_armed),
    .sync_override (sync_override)
);

// File: tb/sim_vfp_cmd_sched.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps the window geometry and the limits, then runs
// the one-shot, low-power, empty-queue and spill-over cases.
module sim_vfp_cmd_sched;
    localparam int LINE = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        active_end = 1'b0, line_strobe = 1'b0;
    logic        cmd_pending = 1'b0, xfer_busy = 1'b0, lp_mode = 1'b0;
    logic [10:0] cfg_stable_lines = '0;
    logic [3:0]  cfg_allow_lines = '0;
    logic [11:0] cfg_send_point = '0;
    logic [15:0] cfg_pkt_count = '0;
    logic        cfg_multi_en = 1'b0, cfg_frame_once = 1'b0, arm_ready = 1'b0;
    logic        cmd_grant, win_open, ready_armed, sync_override;

    int checks = 0, fails = 0;
    bit done = 0;
    bit mon_en = 0;
    int open_cyc, grants, first, run, ovr, open_line;

    vfp_cmd_sched u0 (
        .clk(clk), .rst_n(rst_n), .active_end(active_end), .line_strobe(line_strobe),
        .cmd_pending(cmd_pending), .xfer_busy(xfer_busy), .lp_mode(lp_mode),
        .cfg_stable_lines(cfg_stable_lines), .cfg_allow_lines(cfg_allow_lines),
        .cfg_send_point(cfg_send_point), .cfg_pkt_count(cfg_pkt_count),
        .cfg_multi_en(cfg_multi_en), .cfg_frame_once(cfg_frame_once),
        .arm_ready(arm_ready), .cmd_grant(cmd_grant), .win_open(win_open),
        .ready_armed(ready_armed), .sync_override(sync_override)
    );

    always #4 clk = ~clk;

    // Monitor: collect window statistics away from the active edge
    int line_idx;
    always @(negedge clk) begin
        if (mon_en) begin
            if (cmd_grant) begin
                grants++;
                if (first < 0) first = run;
            end
            if (win_open) begin
                if (run == 0) open_line = line_idx;
                open_cyc++;
                run++;
            end
            if (sync_override) ovr++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One front porch: active_end, then lines spaced LINE cycles apart
    task automatic frame(input int nlines);
        open_cyc = 0; grants = 0; first = -1; run = 0; ovr = 0;
        open_line = -1; line_idx = 0;
        mon_en = 1;
        @(posedge clk); #1 active_end = 1'b1;
        @(posedge clk); #1 active_end = 1'b0;
        for (int k = 1; k <= nlines; k++) begin
            repeat (LINE-1) @(posedge clk);
            #1 line_strobe = 1'b1; line_idx = k;
            @(posedge clk); #1 line_strobe = 1'b0;
        end
        repeat (3) @(posedge clk);
        #1 mon_en = 0;
    endtask

    function automatic int exp_grants(input int allow, input int sp, input int lim, input bit elig);
        int room;
        room = LINE*allow - sp;
        if (!elig || room <= 0) return 0;
        return (room < lim) ? room : lim;
    endfunction

    initial begin
        #(8ns * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int lim, eg;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!cmd_grant && !win_open && !ready_armed && !sync_override, "R1",
            {cmd_grant, win_open, ready_armed, sync_override}, 0);

        cmd_pending = 1'b1;
        cfg_pkt_count = 16'd5;
        // R2 R3 R4 R5 R6: sweep of window geometry and limits
        for (int s = 0; s < 3; s++)
            for (int a = 0; a < 4; a++)
                for (int spi = 0; spi < 3; spi++)
                    for (int m = 0; m < 2; m++) begin
                        cfg_stable_lines = 11'(s);
                        cfg_allow_lines = 4'(a);
                        cfg_send_point = (spi == 0) ? 12'd0 : (spi == 1) ? 12'd3 : 12'd13;
                        cfg_multi_en = m[0];
                        lim = m ? 5 : 1;
                        frame(s + a + 2);
                        chk(open_cyc == LINE*a, "R3 open cycles", open_cyc, LINE*a);
                        if (a > 0) chk(open_line == s, "R2 opening line", open_line, s);
                        eg = exp_grants(a, int'(cfg_send_point), lim, 1'b1);
                        chk(grants == eg, "R5 grant count", grants, eg);
                        if (eg > 0) chk(first == int'(cfg_send_point), "R4 first grant", first, int'(cfg_send_point));
                        chk(ovr == 0, "R11 no override", ovr, 0);
                    end

        // R6: back-to-back windows each get the full limit
        cfg_stable_lines = 11'd1; cfg_allow_lines = 4'd2; cfg_send_point = 12'd0;
        cfg_multi_en = 1'b1; cfg_pkt_count = 16'd4;
        frame(5); chk(grants == 4, "R6 first window", grants, 4);
        frame(5); chk(grants == 4, "R6 second window", grants, 4);

        // R5: multi mode with a count of zero grants nothing
        cfg_pkt_count = 16'd0;
        frame(5); chk(grants == 0, "R5 zero count", grants, 0);
        cfg_pkt_count = 16'd3;

        // R7 R8: one-shot mode
        cfg_frame_once = 1'b1;
        frame(5); chk(grants == 0, "R7 unarmed window", grants, 0);
        @(posedge clk); #1 arm_ready = 1'b1;
        @(posedge clk); #1 arm_ready = 1'b0;
        @(negedge clk); chk(ready_armed == 1'b1, "R8 armed", ready_armed, 1);
        frame(5); chk(grants == 3, "R7 armed window", grants, 3);
        @(negedge clk); chk(ready_armed == 1'b0, "R8 self clear", ready_armed, 0);
        frame(5); chk(grants == 0, "R7 after use", grants, 0);
        cfg_frame_once = 1'b0;
        frame(5); chk(grants == 3, "R7 every window", grants, 3);

        // R9: low-power mode blocks grants, window still runs
        lp_mode = 1'b1;
        frame(5);
        chk(grants == 0, "R9 lp grants", grants, 0);
        chk(open_cyc == 2*LINE, "R9 lp window", open_cyc, 2*LINE);
        lp_mode = 1'b0;

        // R10: empty queue gives no grant
        cmd_pending = 1'b0;
        frame(5); chk(grants == 0, "R10 empty queue", grants, 0);
        cmd_pending = 1'b1;

        // R10 R11: encoder busy across the close
        xfer_busy = 1'b1;
        frame(5);
        chk(grants == 0, "R10 busy grants", grants, 0);
        chk(ovr == 1, "R11 override pulse", ovr, 1);
        xfer_busy = 1'b0;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule